// File: doc/BRIEF.md
# Serial Two-A-Then-B Sequence Recognizer

This block watches a one-bit serial stream and raises a flag while the last three symbols, oldest first, are a, a, b. Symbol a is carried as a low bit and symbol b as a high bit. The flag is a Mealy output. It depends on the stored state and the present input bit, so it rises in the same cycle as the closing b rather than one cycle later.

Progress through the pattern is held in a two-bit state register with a fixed encoding. The next-state bits come from minimal sum-of-products equations. A run of any length of a symbols leaves the machine ready to fire on the next b, so occurrences that overlap are all found. Any b clears progress.

The reset input is asynchronous and active low. Its release is passed through a short synchroniser before it reaches the state register. After reset is released, the stream should carry b symbols for at least as many cycles as the synchroniser has stages.

Top module: `aab_recognizer`

## Requirements
- R1: The flag `y` is high in a cycle exactly when the input bit sampled at the two previous clock edges was 0 (a) and the present input bit is 1 (b). In every other cycle it is low.
- R2: `y` follows the present input bit within the cycle, with no register on the output. In the two-a state, `y` rises and falls as `x` changes between edges, and the state does not change until the next edge.
- R3: While `rst_n` is low, the state is cleared at once without waiting for a clock edge, and `y` stays low whatever `x` is.
- R4: A run of two or more 0 bits followed by a 1 gives exactly one pulse, on that 1. Back-to-back patterns such as 0,0,1,0,0,1 give a pulse on each 1.
- R5: Any 1 bit returns the machine to the no-progress state. After a 1, a later 1 can only flag once two fresh 0 bits have been seen.
- R6: The state encoding is no progress = 00, one a seen = 01, and two or more a seen = 10. Code 11 is never entered from a legal state. If it is entered, it goes to 10 on a 0 and to 00 on a 1, like any other state.
- R7: `y` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| x | input | 1 | Serial symbol: 0 is a, 1 is b |
| y | output | 1 | High while the last three symbols are a, a, b |

## Verification
The bench aims at runs of three or more a symbols. A design that reset its progress on the third a would miss the pulse there. It also sends back-to-back patterns, where a design that did not clear on b, or that registered its output, would give an extra pulse or a late one. It moves `x` between clock edges in the two-a state to show that `y` tracks the input combinationally. It also asserts reset in the middle of a cycle to show that the state clears before the next edge. A long pseudo-random stream is compared with a three-symbol window model. A wrong equation for a single state would show up there as missing or extra pulses.

// File: rtl/aab_pkg.sv
package aab_pkg;

  localparam int STATE_W = 2;

  // symbol coding on the serial input
  localparam logic SYM_A = 1'b0;
  localparam logic SYM_B = 1'b1;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'b00,  // no progress
    ST_ONE_A = 2'b01,  // one a seen
    ST_TWO_A = 2'b10,  // two or more a seen
    ST_SPARE = 2'b11   // unused code
  } state_e;

endpackage

// File: rtl/aab_reset_sync.sv
module aab_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // assert asynchronously, release after STAGES rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/aab_next_state.sv
module aab_next_state
  import aab_pkg::*;
(
  input  state_e cur_state,
  input  logic   sym_in,
  output state_e nxt_state
);

  logic q1, q0, is_a;
  logic d1, d0;

  always_comb begin
    q1   = cur_state[1];
    q0   = cur_state[0];
    is_a = (sym_in == SYM_A);
    // minimal excitation equations for D flops
    d1 = (is_a & q0) | (is_a & q1);
    d0 = ~q1 & ~q0 & is_a;
    nxt_state = state_e'({d1, d0});
  end

endmodule

// File: rtl/aab_state_reg.sv
module aab_state_reg
  import aab_pkg::*;
(
  input  logic   clk,
  input  logic   rst_sync_n,
  input  state_e nxt_state,
  output state_e cur_state
);

  logic   upd_en;
  state_e state_q;

  // explicit enable: the machine advances on every edge out of reset
  assign upd_en = 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
    end else if (upd_en) begin
      state_q <= nxt_state;
    end
  end

  assign cur_state = state_q;

endmodule

// File: rtl/aab_output.sv
module aab_output (
  input  logic prog_hi,
  input  logic sym_in,
  output logic flag
);

  // Mealy output: high bit of state and present symbol b
  assign flag = prog_hi & sym_in;

endmodule

// File: rtl/aab_recognizer.sv
module aab_recognizer
  import aab_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x,
  output logic y
);

  logic   rst_sync_n;
  state_e cur_state;
  state_e nxt_state;

  aab_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  aab_next_state u_ns (
    .cur_state (cur_state),
    .sym_in    (x),
    .nxt_state (nxt_state)
  );

  aab_state_reg u_sr (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .nxt_state  (nxt_state),
    .cur_state  (cur_state)
  );

  aab_output u_out (
    .prog_hi (cur_state[1]),
    .sym_in  (x),
    .flag    (y)
  );

  // R1: a pulse is preceded by two a symbols at the last two edges
  p_history_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    y |-> ($past(x) == SYM_A) && ($past(x, 2) == SYM_A));

  // R3: a low reset clears the state by the following edge
  p_reset_clear_r3: assert property (@(posedge clk)
    !rst_n |=> (cur_state == ST_IDLE));

  // R4: an a with progress lands in the two-a state
  p_a_advances_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (x == SYM_A) && (cur_state != ST_IDLE) |=> (cur_state == ST_TWO_A));

  // R5: any b clears progress
  p_b_clears_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (x == SYM_B) |=> (cur_state == ST_IDLE));

  // R6: the spare code is never held
  p_no_spare_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cur_state != ST_SPARE);

  // R7: no two pulses in a row
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    y |=> !y);

endmodule

// File: tb/aab_recognizer_bench.sv
`timescale 1ns/1ps
module aab_recognizer_bench;

  logic clk;
  logic rst_n;
  logic x;
  logic y;

  int checks = 0;
  int errors = 0;
  logic [1:0] hist;  // hist[0] most recent sampled symbol

  // {x, expected y}, walked from the no-progress state
  localparam int NV = 26;
  localparam logic [1:0] VEC [NV] = '{
    2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b10,
    2'b00, 2'b10, 2'b00, 2'b10, 2'b00, 2'b00, 2'b11, 2'b00,
    2'b00, 2'b11, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11,
    2'b10, 2'b10
  };

  aab_recognizer u_aab_recognizer (
    .clk   (clk),
    .rst_n (rst_n),
    .x     (x),
    .y     (y)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // drive one symbol, compare with the window model, then clock it in
  task automatic step(input logic xi, input string tag);
    @(negedge clk);
    x = xi;
    #2;
    check(y, xi & ~hist[0] & ~hist[1], tag);
    @(posedge clk);
    hist = {hist[0], xi};
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0;
    x     = 1'b1;
    hist  = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(y, 1'b0, "R3 reset state");
    rst_n = 1'b1;
    repeat (4) step(1'b1, "R3 idle after release");

    // table walk: R1 expected values, R4 overlapping runs
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      x = VEC[i][1];
      #2;
      check(y, VEC[i][0], "R1 table");
      check(y, VEC[i][1] & ~hist[0] & ~hist[1], "R4 table model");
      @(posedge clk);
      hist = {hist[0], VEC[i][1]};
    end

    // R2: output follows x inside a cycle in the two-a state
    step(1'b1, "R2 prep");
    step(1'b0, "R2 prep");
    step(1'b0, "R2 prep");
    @(negedge clk);
    x = 1'b0; #1; check(y, 1'b0, "R2 x low");
    x = 1'b1; #1; check(y, 1'b1, "R2 x high");
    x = 1'b0; #1; check(y, 1'b0, "R2 x low again");
    @(posedge clk);
    hist = {hist[0], 1'b0};
    step(1'b1, "R2 state kept");

    // R3: asynchronous clear mid-cycle
    step(1'b0, "R3 prep");
    step(1'b0, "R3 prep");
    @(negedge clk);
    x = 1'b1; #1; check(y, 1'b1, "R3 before reset");
    rst_n = 1'b0; #1; check(y, 1'b0, "R3 async clear");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      x = i[0]; #2;
      check(y, 1'b0, "R3 held in reset");
    end
    x = 1'b1;
    rst_n = 1'b1;
    hist = 2'b11;
    repeat (4) step(1'b1, "R3 idle after release");

    // R5: b clears progress
    step(1'b0, "R5"); step(1'b1, "R5"); step(1'b0, "R5"); step(1'b1, "R5");
    step(1'b0, "R5"); step(1'b1, "R5"); step(1'b1, "R5");

    // R7: pulse then a second b
    step(1'b0, "R7"); step(1'b0, "R7"); step(1'b1, "R7"); step(1'b1, "R7");

    // R4 R6: long stream against the window model
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[3], "R6 R4 stream");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule